// File: doc/BRIEF.md
# CAN Receive Bit Sampler and Destuffer

This block turns an oversampled CAN receive line into a clean stream of frame bits for a downstream frame parser. While idle it watches the line. The first dominant (0) level it sees is taken as the start-of-frame bit, and the clock edge on which that level is seen becomes the time origin of the frame. From that origin the block steps through nominal bit times of a programmable number of clocks. It samples the line once per bit, at a programmable percentage of the bit time.

Each sampled bit goes through a destuffing stage. After five equal bits in a row, the next raw bit is a stuff bit. A stuff bit still occupies a full bit time, but it is not passed on. If that stuff bit has the same value as the run before it, the block reports a stuff violation. The parser raises a stop input once the stuffed part of the frame is over. From then on every sampled bit is delivered unchanged. The parser pulses a done input to send the block back to idle.

Top module: `can_bit_sampler`

## Requirements
- R1: While reset is high, and on the first cycle after it, bit_valid, bit_value, bit_first and stuff_error are all 0 and the block is idle.
- R2: In idle a recessive line (rx = 1) produces no output, whatever its duration.
- R3: The first edge in idle at which rx = 0 is edge 0 of the start-of-frame bit. That bit is delivered with bit_value = 0 and bit_first = 1. No later bit of the same frame carries bit_first.
- R4: The sample offset is floor(clks_per_bit * sample_pct / 100). It is raised to 1 if smaller and lowered to clks_per_bit - 1 if larger. The offset and the bit time are both captured at the start-of-frame edge, so any change to the settings during a frame has no effect on that frame.
- R5: Raw bit k of a frame, with stuff bits included in the count, is sampled at edge S + k*clks_per_bit + offset, where S is the start-of-frame edge. A delivered bit appears as a one-cycle bit_valid pulse in the cycle that follows its sample edge.
- R6: While destuff_stop is 0, a raw bit that follows five equal consecutive bits is a stuff bit and is not delivered. The stuff bit then begins a new run of length 1 with its own value.
- R7: A stuff bit with the same value as the five bits before it raises stuff_error for one cycle, with the same timing as R5, and with bit_valid low.
- R8: A raw bit sampled while destuff_stop is 1 is always delivered. It never raises stuff_error.
- R9: A pulse on frame_done returns the block to idle and clears all of its counters. No output appears in the following cycle. The next dominant level starts a new frame, subject to R3.
- R10: bit_valid is never high in two consecutive cycles, and bit_first is high only together with bit_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the line |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Receive line, 0 = dominant, already synchronised |
| clks_per_bit | input | CPB_W | Nominal bit time in clocks (at least 4) |
| sample_pct | input | PCT_W | Sample point as a percentage of the bit time |
| destuff_stop | input | 1 | High once the stuffed part of the frame has ended |
| frame_done | input | 1 | Pulse that returns the block to idle |
| bit_valid | output | 1 | One-cycle strobe for a delivered frame bit |
| bit_value | output | 1 | Value of the delivered bit |
| bit_first | output | 1 | Marks the start-of-frame bit |
| stuff_error | output | 1 | One-cycle strobe for a stuff violation |

## Verification
Every result has a fixed due cycle. It lands one clock after edge S + k*clks_per_bit + offset, where k counts raw bits and stuff bits are included. The scoreboard driver stamps each expected item with that exact cycle, working from the requirements. The monitor samples on the falling edge and compares the cycle stamp together with the value, first flag and error flag. A pulse that comes early, comes late or is missing is therefore reported. Any output that has no queued item, such as output from an idle line or after an abort, is reported as unexpected.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rx_state_t;

    // one sampled line value, before destuffing
    typedef struct packed {
        logic valid;
        logic value;
        logic first;
    } raw_bit_t;

    // registered result toward the parser
    typedef struct packed {
        logic valid;
        logic value;
        logic first;
        logic stuff_err;
    } out_bit_t;

    // offset of the sample edge inside a bit, clamped to [1, cpb-1]
    function automatic logic [31:0] sample_offset(input logic [31:0] cpb,
                                                  input logic [31:0] pct);
        logic [31:0] q;
        q = (cpb * pct) / 32'd100;
        if (q < 32'd1)
            q = 32'd1;
        if (q >= cpb)
            q = cpb - 32'd1;
        return q;
    endfunction

endpackage

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_rx_pkg::*;
#(
    parameter int CPB_W = 16,
    parameter int PCT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rx,
    input  logic [CPB_W-1:0] clks_per_bit,
    input  logic [PCT_W-1:0] sample_pct,
    output raw_bit_t         raw_o
);

    rx_state_t        state_q;
    logic [CPB_W-1:0] cnt_q;
    logic [CPB_W-1:0] pos_q;
    logic [CPB_W-1:0] wrap_q;
    logic             first_q;
    logic [CPB_W-1:0] off_w;
    logic             hit_w;

    assign off_w = CPB_W'(sample_offset(32'(clks_per_bit), 32'(sample_pct)));
    assign hit_w = (state_q == ST_RUN) && (cnt_q == pos_q);

    // sample strobe is combinational; the destuffer registers it
    always_comb begin
        raw_o.valid = hit_w;
        raw_o.value = rx;
        raw_o.first = hit_w & first_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
            wrap_q  <= '0;
            first_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!rx) begin
                        // this edge is cycle 0 of the start-of-frame bit
                        state_q <= ST_RUN;
                        cnt_q   <= CPB_W'(1);
                        pos_q   <= off_w;
                        wrap_q  <= clks_per_bit - CPB_W'(1);
                        first_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (hit_w)
                        first_q <= 1'b0;
                    if (cnt_q == wrap_q)
                        cnt_q <= '0;
                    else
                        cnt_q <= cnt_q + CPB_W'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/can_destuffer.sv
module can_destuffer
    import can_rx_pkg::*;
#(
    parameter int STUFF_LEN = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  raw_bit_t raw_i,
    input  logic     destuff_stop,
    output out_bit_t out_o
);

    localparam int RUN_W = $clog2(STUFF_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_LEN);

    logic [RUN_W-1:0] run_q;
    logic             last_q;
    out_bit_t         out_q;
    logic             stuff_w;
    logic             same_w;

    assign same_w  = (raw_i.value == last_q);
    assign stuff_w = !destuff_stop && !raw_i.first && (run_q == RUN_MAX);
    assign out_o   = out_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_q  <= '0;
            run_q  <= '0;
            last_q <= 1'b0;
        end else begin
            out_q <= '0;
            if (raw_i.valid) begin
                last_q <= raw_i.value;
                if (stuff_w) begin
                    out_q.stuff_err <= same_w;
                    run_q           <= RUN_W'(1);
                end else begin
                    out_q.valid <= 1'b1;
                    out_q.value <= raw_i.value;
                    out_q.first <= raw_i.first;
                    if (!raw_i.first && same_w) begin
                        if (run_q != RUN_MAX)
                            run_q <= run_q + RUN_W'(1);
                    end else begin
                        run_q <= RUN_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
    import can_rx_pkg::*;
#(
    parameter int CPB_W     = 16,
    parameter int PCT_W     = 7,
    parameter int STUFF_LEN = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx,
    input  logic [CPB_W-1:0] clks_per_bit,
    input  logic [PCT_W-1:0] sample_pct,
    input  logic             destuff_stop,
    input  logic             frame_done,
    output logic             bit_valid,
    output logic             bit_value,
    output logic             bit_first,
    output logic             stuff_error
);

    raw_bit_t raw_w;
    out_bit_t res_w;

    can_bit_timer #(
        .CPB_W (CPB_W),
        .PCT_W (PCT_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .clr          (frame_done),
        .rx           (rx),
        .clks_per_bit (clks_per_bit),
        .sample_pct   (sample_pct),
        .raw_o        (raw_w)
    );

    can_destuffer #(
        .STUFF_LEN (STUFF_LEN)
    ) u_destuff (
        .clk          (clk),
        .rst          (rst),
        .clr          (frame_done),
        .raw_i        (raw_w),
        .destuff_stop (destuff_stop),
        .out_o        (res_w)
    );

    assign bit_valid   = res_w.valid;
    assign bit_value   = res_w.value;
    assign bit_first   = res_w.first;
    assign stuff_error = res_w.stuff_err;

endmodule

// File: rtl/can_bit_sampler_chk.sv
module can_bit_sampler_chk (
    input logic clk,
    input logic rst,
    input logic destuff_stop,
    input logic frame_done,
    input logic bit_valid,
    input logic bit_first,
    input logic stuff_error
);

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid); // R10

    AST_FIRST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        bit_first |-> bit_valid); // R10

    AST_ERR_NOT_DELIVERED: assert property (@(posedge clk) disable iff (rst)
        stuff_error |-> !bit_valid); // R7

    AST_DONE_SILENCES: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !(bit_valid || stuff_error)); // R9

    AST_NO_ERR_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        destuff_stop |=> !stuff_error); // R8

endmodule

bind can_bit_sampler can_bit_sampler_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .destuff_stop (destuff_stop),
    .frame_done   (frame_done),
    .bit_valid    (bit_valid),
    .bit_first    (bit_first),
    .stuff_error  (stuff_error)
);

// File: tb/sim_can_bit_sampler.sv
`timescale 1ns/1ps
module sim_can_bit_sampler;

    localparam int CPB_W = 16;
    localparam int PCT_W = 7;

    logic             clk = 1'b0;
    logic             rst;
    logic             rx;
    logic [CPB_W-1:0] clks_per_bit;
    logic [PCT_W-1:0] sample_pct;
    logic             destuff_stop;
    logic             frame_done;
    logic             bit_valid;
    logic             bit_value;
    logic             bit_first;
    logic             stuff_error;

    typedef struct {
        bit    val;
        bit    first;
        bit    err;
        int    cyc;
        string req;
    } exp_t;

    exp_t  expq[$];
    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    int    n_out = 0;
    string cur_req = "R2";
    bit    done_flag = 0;

    can_bit_sampler #(.CPB_W(CPB_W), .PCT_W(PCT_W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .rx           (rx),
        .clks_per_bit (clks_per_bit),
        .sample_pct   (sample_pct),
        .destuff_stop (destuff_stop),
        .frame_done   (frame_done),
        .bit_valid    (bit_valid),
        .bit_value    (bit_value),
        .bit_first    (bit_first),
        .stuff_error  (stuff_error)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // monitor: pops one expected item per output strobe; code = cyc*8+val*4+first*2+err
    always @(negedge clk) begin
        if (!rst && (bit_valid || stuff_error)) begin
            n_out++;
            if (expq.size() == 0) begin
                check(0, cur_req, "unexpected output at cycle", cyc, -1);
            end else begin
                exp_t e;
                int act_c;
                int exp_c;
                e = expq.pop_front();
                act_c = cyc * 8 + ((bit_valid && bit_value) ? 4 : 0)
                      + (bit_first ? 2 : 0) + (stuff_error ? 1 : 0);
                exp_c = e.cyc * 8 + ((!e.err && e.val) ? 4 : 0)
                      + (e.first ? 2 : 0) + (e.err ? 1 : 0);
                check(act_c == exp_c && (bit_valid == !e.err), e.req,
                      "item code (cyc*8+val*4+first*2+err)", act_c, exp_c);
            end
            if (bit_first)
                check(bit_valid, "R10", "bit_first without bit_valid", 0, 1);
        end
    end

    // driver: builds expected items from the requirements, then drives the line
    task automatic run_frame(input string bits, input int cpb, input int pct,
                             input int stop_at, input bit chg, input string req);
        int pos;
        int c0;
        int run;
        bit last;
        int n;
        n = bits.len();
        pos = (cpb * pct) / 100;
        if (pos < 1) pos = 1;
        if (pos > cpb - 1) pos = cpb - 1;
        @(negedge clk);
        clks_per_bit = CPB_W'(cpb);
        sample_pct   = PCT_W'(pct);
        cur_req      = req;
        @(negedge clk);
        c0 = cyc + 1;
        run = 0;
        last = 0;
        for (int k = 0; k < n; k++) begin
            bit v;
            exp_t e;
            v = (bits[k] == "1");
            e.req = req;
            e.cyc = c0 + k * cpb + pos;
            e.val = v;
            e.first = 0;
            e.err = 0;
            if (k == 0) begin
                e.first = 1;
                expq.push_back(e);
                run = 1;
            end else if (k < stop_at && run == 5) begin
                // stuff bit: dropped, flagged only if equal to the run (R6, R7)
                if (v == last) begin
                    e.err = 1;
                    expq.push_back(e);
                end
                run = 1;
            end else begin
                expq.push_back(e);
                if (v == last) begin
                    if (run < 5) run++;
                end else begin
                    run = 1;
                end
            end
            last = v;
        end
        for (int k = 0; k < n; k++) begin
            rx = (bits[k] == "1");
            destuff_stop = (k >= stop_at);
            if (chg && k == 1) begin
                clks_per_bit = CPB_W'(cpb + 3);
                sample_pct   = PCT_W'(90);
            end
            repeat (cpb) @(negedge clk);
        end
        rx = 1'b1;
        frame_done = 1'b1;
        destuff_stop = 1'b0;
        @(negedge clk);
        frame_done = 1'b0;
        repeat (3) @(negedge clk);
        check(expq.size() == 0, req, "expected items never produced", expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R1", "watchdog expired", cyc, 150000);
        finish_sim();
    end

    initial begin
        int seen;
        rst = 1'b1;
        rx = 1'b1;
        clks_per_bit = CPB_W'(10);
        sample_pct = PCT_W'(70);
        destuff_stop = 1'b0;
        frame_done = 1'b0;
        repeat (3) @(negedge clk);
        check(bit_valid == 1'b0, "R1", "bit_valid in reset", bit_valid, 0);
        check(bit_value == 1'b0, "R1", "bit_value in reset", bit_value, 0);
        check(bit_first == 1'b0, "R1", "bit_first in reset", bit_first, 0);
        check(stuff_error == 1'b0, "R1", "stuff_error in reset", stuff_error, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bit_valid && !stuff_error, "R1", "output after reset release", bit_valid, 0);

        // R2: long recessive idle
        cur_req = "R2";
        seen = n_out;
        repeat (60) @(negedge clk);
        check(n_out == seen, "R2", "outputs on recessive idle line", n_out - seen, 0);

        // R3 and R5: plain frame without stuffing
        run_frame("0101100101110", 10, 70, 99, 0, "R3");
        run_frame("0110100110", 7, 40, 99, 0, "R5");
        // R6: two stuff bits of opposite value
        run_frame("000001111101001", 8, 50, 99, 0, "R6");
        // R7: stuff bit equal to the run
        run_frame("0111111010", 6, 60, 99, 0, "R7");
        // R8: stuffing switched off from raw bit 3
        run_frame("0101111111000000", 9, 70, 3, 0, "R8");
        // R4: low clamp and settings changed mid-frame
        run_frame("01101001", 12, 5, 99, 1, "R4");
        // R4: late sample point
        run_frame("0011010", 20, 95, 99, 0, "R4");
        // R9: aborted frame, then a fresh frame with bit_first
        run_frame("011", 10, 70, 99, 0, "R9");
        run_frame("0101", 10, 70, 99, 0, "R9");

        cur_req = "R2";
        seen = n_out;
        repeat (40) @(negedge clk);
        check(n_out == seen, "R2", "outputs on idle line after frames", n_out - seen, 0);
        finish_sim();
    end

endmodule